// File: doc/BRIEF.md
# Prescaled Dual Interval Timer

This block holds three 16-bit down-counters that share one byte-wide register port. Counter 2 runs from a master clock enable and acts as a prescaler. Each terminal pulse it produces is the only step that counters 0 and 1 receive. Counter 0 supplies the periodic system tick interrupt. Counter 1 is normally loaded with 0xFFFF and runs as a free timebase that raises its own interrupt each time it wraps.

Software loads a counter by writing a control byte that selects the counter and a command, then writing the 16-bit reload value as two bytes. It can freeze a counter's value for a coherent two-byte read. Each interrupt flag is cleared by writing a one to its bit of a clear register. Every counter runs in rate-generation mode only.

Top module: `prescaled_timer_unit`

## Requirements
- R1: Counter 2 advances only on clock edges where `tick_en` is high, and each of its terminal pulses advances counters 0 and 1 once. With reloads R2 and R0 and `tick_en` always high, the tick interrupt therefore repeats every R0*R2 clocks, or every 2*R0*R2 clocks when `tick_en` is high on alternate clocks. A prescale of 8 gives counters 0 and 1 one step per 8 master enables.
- R2: Counters 0, 1 and 2 have data addresses 0, 1 and 2. A reload value is written there as two byte writes, low byte first and high byte second. The counter starts only on the high-byte write.
- R3: Address 3 is the control register. Bits 7:6 select the counter (0, 1 or 2; 3 selects none), and bits 1:0 select the command: 01 rate generation, 10 stop, 11 latch, 00 nothing. A rate-generation command halts the selected counter and makes its next data write a low byte.
- R4: A running counter with reload R counts down one per step. On the step taken at count 1 it gives a terminal pulse lasting one clock and reloads R, so it pulses once every R steps.
- R5: A reload value of 0 or 1 is rejected. The counter stays stopped and raises no interrupt.
- R6: `irq_tick` is set by a counter-0 terminal pulse and `irq_wrap` by a counter-1 terminal pulse. Each flag stays set until it is cleared.
- R7: Address 4 is the clear register. A write with bit 0 set clears `irq_tick`, a write with bit 1 set clears `irq_wrap`, 0x03 clears both, and a zero bit leaves its flag alone. A terminal pulse in the same clock as a clear wins.
- R8: A stop command halts the selected counter. It raises no further interrupt until a new reload value has been written.
- R9: A latch command freezes the selected counter's current value. The next two reads of that counter return the low byte and then the high byte of the frozen value, while counting continues. A second latch command before both bytes have been read is ignored.
- R10: With no latch pending, reads of a counter address alternate between the low byte and the high byte of its live count. Reads of other addresses, and `rdata` with `rd_en` low, give 0.
- R11: After reset all counters are stopped with count 0, both interrupt flags are clear, and the byte order of writes and reads begins at the low byte.
- R12: Counter 1 loaded with 0xFFFF raises `irq_wrap` once every 65535 prescaled steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Master clock enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of a counter advances its byte order |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while `rd_en` is high |
| irq_tick | output | 1 | Counter 0 interrupt flag |
| irq_wrap | output | 1 | Counter 1 interrupt flag |

## Verification
The assertions assume that a clear write takes its bit mask from `wdata`, and that `wr_en` and `rd_en` are never high in the same clock. They also assume the prescaler is only ever started with a reload of at least 2, which the block enforces. The stimulus keeps to these by driving writes and reads from separate tasks, one strobe at a time, and by changing inputs only at the falling edge. Periods are measured between two flag rises with a clear in between, so the phase between prescaler and counter does not affect the expected counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_RATE  = 2'b01,
    CMD_STOP  = 2'b10,
    CMD_LATCH = 2'b11
  } tmr_cmd_e;
endpackage

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              cmd_valid,
  input  tmr_pkg::tmr_cmd_e cmd,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tc_o,
  output logic              running_o
);
  import tmr_pkg::*;
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] MIN_RELOAD = CNT_W'(2);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rel);
    return (cur == CNT_W'(1)) ? rel : cur - CNT_W'(1);
  endfunction

  function automatic logic at_terminal(input logic [CNT_W-1:0] cur);
    return cur == CNT_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] pick_byte(input logic [CNT_W-1:0] val,
                                                  input logic hi);
    return hi ? val[CNT_W-1:DATA_W] : val[DATA_W-1:0];
  endfunction

  logic              running;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  reload;
  logic              wr_hi;
  logic [DATA_W-1:0] lo_buf;
  logic              latched;
  logic [CNT_W-1:0]  latch_val;
  logic              rd_hi;
  logic [CNT_W-1:0]  new_reload;
  logic              halt_cmd;

  assign new_reload = {wdata, lo_buf};
  assign halt_cmd   = cmd_valid && (cmd == CMD_RATE || cmd == CMD_STOP);
  assign tc_o       = running && step && at_terminal(count);
  assign running_o  = running;
  assign rdata_o    = pick_byte(latched ? latch_val : count, rd_hi);

  // load and count path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
      reload  <= '0;
      wr_hi   <= 1'b0;
      lo_buf  <= '0;
    end else if (halt_cmd) begin
      running <= 1'b0;
      wr_hi   <= 1'b0;
    end else if (data_wr) begin
      if (!wr_hi) begin
        lo_buf <= wdata;
        wr_hi  <= 1'b1;
      end else begin
        wr_hi <= 1'b0;
        if (new_reload >= MIN_RELOAD) begin
          reload  <= new_reload;
          count   <= new_reload;
          running <= 1'b1;
        end else begin
          running <= 1'b0;
        end
      end
    end else if (running && step) begin
      count <= next_count(count, reload);
    end
  end

  // latch and read-order path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched   <= 1'b0;
      latch_val <= '0;
      rd_hi     <= 1'b0;
    end else if (cmd_valid && cmd == CMD_LATCH) begin
      if (!latched) begin
        latched   <= 1'b1;
        latch_val <= count;
        rd_hi     <= 1'b0;
      end
    end else if (data_rd) begin
      rd_hi <= !rd_hi;
      if (rd_hi) latched <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int NUM_IRQ = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] set_i,
  input  logic               clr_wr,
  input  logic [NUM_IRQ-1:0] clr_bits,
  output logic [NUM_IRQ-1:0] flags_o
);
  function automatic logic [NUM_IRQ-1:0] flag_next(input logic [NUM_IRQ-1:0] cur,
                                                   input logic [NUM_IRQ-1:0] clr,
                                                   input logic [NUM_IRQ-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  logic [NUM_IRQ-1:0] clr_mask;
  assign clr_mask = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= flag_next(flags_o, clr_mask, set_i);
  end
endmodule

// File: rtl/prescaled_timer_unit.sv
module prescaled_timer_unit #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_tick,
  output logic              irq_wrap
);
  import tmr_pkg::*;
  localparam int NUM_CNT = 3;
  localparam int PRE_IDX = NUM_CNT - 1;
  localparam int NUM_IRQ = NUM_CNT - 1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_CNT);
  localparam logic [ADDR_W-1:0] ADDR_CLR  = ADDR_W'(NUM_CNT + 1);

  logic                ctrl_wr;
  logic                clr_wr;
  logic [1:0]          ctrl_sel;
  tmr_cmd_e            ctrl_cmd;
  logic                pre_tc;
  logic [NUM_IRQ-1:0]  user_tc;
  logic [NUM_CNT-1:0]  cnt_run;
  logic [DATA_W-1:0]   rd_arr [NUM_CNT];
  logic [NUM_IRQ-1:0]  flags;

  assign ctrl_wr  = wr_en && (addr == ADDR_CTRL);
  assign clr_wr   = wr_en && (addr == ADDR_CLR);
  assign ctrl_sel = wdata[DATA_W-1 -: 2];
  assign ctrl_cmd = tmr_cmd_e'(wdata[1:0]);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic cv, dw, dr;
    assign cv = ctrl_wr && (ctrl_sel == 2'(i));
    assign dw = wr_en && (addr == ADDR_W'(i));
    assign dr = rd_en && (addr == ADDR_W'(i));
    if (i == PRE_IDX) begin : g_pre
      tmr_down_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(tick_en), .cmd_valid(cv),
        .cmd(ctrl_cmd), .data_wr(dw), .data_rd(dr), .wdata(wdata),
        .rdata_o(rd_arr[i]), .tc_o(pre_tc), .running_o(cnt_run[i]));
    end else begin : g_usr
      tmr_down_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(pre_tc), .cmd_valid(cv),
        .cmd(ctrl_cmd), .data_wr(dw), .data_rd(dr), .wdata(wdata),
        .rdata_o(rd_arr[i]), .tc_o(user_tc[i]), .running_o(cnt_run[i]));
    end
  end

  tmr_irq_flags #(.NUM_IRQ(NUM_IRQ)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(user_tc), .clr_wr(clr_wr),
    .clr_bits(wdata[NUM_IRQ-1:0]), .flags_o(flags));

  assign irq_tick = flags[0];
  assign irq_wrap = flags[1];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rd_en && addr == ADDR_W'(i)) rdata = rd_arr[i];
    end
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int NUM_CNT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic               pre_tc,
  input logic [NUM_CNT-2:0] user_tc,
  input logic [NUM_CNT-1:0] running,
  input logic               irq_tick,
  input logic               irq_wrap,
  input logic               clr_wr,
  input logic [1:0]         clr_bits
);
  AST_PRESCALE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tc |-> tick_en); // R1
  AST_CASCADE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    user_tc[0] |-> pre_tc); // R1
  AST_CASCADE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    user_tc[1] |-> pre_tc); // R1
  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tc |=> !pre_tc); // R4
  AST_TICK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    user_tc[0] |=> irq_tick); // R6
  AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    user_tc[1] |=> irq_wrap); // R6
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tick && !(clr_wr && clr_bits[0])) |=> irq_tick); // R6
  AST_TICK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tick) |-> $past(user_tc[0])); // R6
  AST_TICK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[0] && !user_tc[0]) |=> !irq_tick); // R7
  AST_WRAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[1] && !user_tc[1]) |=> !irq_wrap); // R7
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running[0] |-> !user_tc[0]); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!irq_tick && !irq_wrap)); // R11
endmodule

bind prescaled_timer_unit tmr_unit_chk #(.NUM_CNT(3)) i_tmr_unit_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pre_tc(pre_tc),
  .user_tc(user_tc), .running(cnt_run), .irq_tick(irq_tick),
  .irq_wrap(irq_wrap), .clr_wr(clr_wr), .clr_bits(wdata[1:0]));

// File: tb/test_prescaled_timer_unit.sv
`timescale 1ns/1ps
module test_prescaled_timer_unit;
  localparam logic [2:0] A_C0 = 3'd0, A_C1 = 3'd1, A_C2 = 3'd2,
                         A_CTRL = 3'd3, A_CLR = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic tick_alt = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_tick, irq_wrap;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prescaled_timer_unit i_prescaled_timer_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_tick(irq_tick), .irq_wrap(irq_wrap));

  initial forever begin
    @(negedge clk);
    tick_en <= tick_alt ? ~tick_en : 1'b1;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [2:0] a, input int exp, input string tag);
    rd_en = 1'b1; addr = a;
    #1 check(tag, rdata, exp);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic program_cnt(input int ctr, input int value);
    wr(A_CTRL, {2'(ctr), 4'b0000, 2'b01});
    wr(3'(ctr), value[7:0]);
    wr(3'(ctr), value[15:8]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; tick_alt = 1'b0;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(1);
  endtask

  // clocks between two tick-flag rises, with a clear in between
  task automatic measure_tick(input int exp, input string tag);
    int n = 0;
    int cnt = 1;
    wr(A_CLR, 8'h01);
    while (!irq_tick && n < 20000) begin @(negedge clk); n++; end
    wr(A_CLR, 8'h01);
    do begin @(negedge clk); cnt++; end while (!irq_tick && cnt < 20000);
    check(tag, cnt, exp);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 irq_tick after reset", irq_tick, 0);
    check("R11 irq_wrap after reset", irq_wrap, 0);
    rd_expect(A_C0, 0, "R11 counter0 count after reset");
    rd_expect(A_C2, 0, "R11 counter2 count after reset");
    rd_expect(A_CTRL, 0, "R10 read of non-counter address");
  endtask

  task automatic t_basic();
    do_reset();
    program_cnt(0, 5);
    wr(A_CTRL, 8'h81);
    wr(A_C2, 8'd3);
    wait_cycles(40);
    check("R2 no count before high byte", irq_tick, 0);
    wr(A_C2, 8'd0);
    measure_tick(15, "R4 R1 tick period 5x3");
    measure_tick(15, "R6 tick period repeat");
    do_reset();
    program_cnt(0, 4);
    program_cnt(2, 8);
    measure_tick(32, "R1 prescale 8 tick period");
  endtask

  task automatic t_gated();
    do_reset();
    tick_alt = 1'b1;
    program_cnt(0, 4);
    program_cnt(2, 3);
    measure_tick(24, "R1 tick_en alternate clocks");
    tick_alt = 1'b0;
  endtask

  task automatic t_byte_order();
    do_reset();
    program_cnt(2, 2);
    wr(A_CTRL, 8'h01);
    wr(A_C0, 8'h09);
    wr(A_CTRL, 8'h01);   // R3 rate command restarts at low byte
    wr(A_C0, 8'd4);
    wr(A_C0, 8'd0);
    measure_tick(8, "R3 byte order reset by rate command");
  endtask

  task automatic t_small_reload();
    do_reset();
    program_cnt(2, 2);
    program_cnt(0, 1);
    wait_cycles(60);
    check("R5 reload 1 rejected", irq_tick, 0);
    program_cnt(0, 0);
    wait_cycles(60);
    check("R5 reload 0 rejected", irq_tick, 0);
    program_cnt(0, 2);
    measure_tick(4, "R5 reload 2 accepted");
  endtask

  task automatic t_stop();
    do_reset();
    program_cnt(0, 3);
    program_cnt(2, 2);
    measure_tick(6, "R8 period before stop");
    wr(A_CTRL, 8'h02);
    wr(A_CLR, 8'h01);
    wait_cycles(80);
    check("R8 no tick after stop", irq_tick, 0);
    program_cnt(0, 3);
    measure_tick(6, "R8 tick resumes after reload");
  endtask

  task automatic t_clear();
    do_reset();
    program_cnt(1, 3);
    program_cnt(0, 2);
    program_cnt(2, 2);
    wait_cycles(40);
    wr(A_CTRL, 8'h82);
    check("R6 tick flag held", irq_tick, 1);
    check("R6 wrap flag held", irq_wrap, 1);
    wr(A_CLR, 8'h00);
    check("R7 zero write keeps tick", irq_tick, 1);
    check("R7 zero write keeps wrap", irq_wrap, 1);
    wr(A_CLR, 8'h02);
    check("R7 bit1 clears wrap", irq_wrap, 0);
    check("R7 bit1 leaves tick", irq_tick, 1);
    wr(A_CLR, 8'h01);
    check("R7 bit0 clears tick", irq_tick, 0);
    program_cnt(2, 2);
    wait_cycles(40);
    wr(A_CTRL, 8'h82);
    wr(A_CLR, 8'h03);
    check("R7 0x03 clears tick", irq_tick, 0);
    check("R7 0x03 clears wrap", irq_wrap, 0);
  endtask

  task automatic t_reads();
    do_reset();
    program_cnt(1, 16'hABCD);
    rd_expect(A_C1, 8'hCD, "R10 live low byte");
    rd_expect(A_C1, 8'hAB, "R10 live high byte");
    rd_expect(A_C1, 8'hCD, "R10 order wraps to low");
    rd_expect(A_C1, 8'hAB, "R10 high again");
    do_reset();
    program_cnt(1, 16'h1234);
    wr(A_CTRL, 8'h43);
    program_cnt(2, 2);
    wait_cycles(19);
    wr(A_CTRL, 8'h43);   // second latch ignored
    wr(A_CTRL, 8'h82);   // 10 prescaled steps so far
    rd_expect(A_C1, 8'h34, "R9 latched low byte");
    rd_expect(A_C1, 8'h12, "R9 latched high byte");
    rd_expect(A_C1, 8'h2A, "R9 live low after latch released");
    rd_expect(A_C1, 8'h12, "R9 live high after latch released");
  endtask

  task automatic t_wrap();
    do_reset();
    program_cnt(1, 16'hFFFF);
    program_cnt(2, 2);
    wait_cycles(131069);
    check("R12 no wrap before 65535 steps", irq_wrap, 0);
    wait_cycles(1);
    check("R12 wrap after 65535 steps", irq_wrap, 1);
    check("R12 tick untouched", irq_tick, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_gated();
    t_byte_order();
    t_small_reload();
    t_stop();
    t_clear();
    t_reads();
    t_wrap();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule